// File: doc/BRIEF.md
# Watchdog Timer with Selectable Clear Discipline

This block guards a processor against runaway software. A counter advances on a selectable time base. Software has to restart it before it reaches a configured limit. If the count reaches that limit, the block raises a single-cycle reset request and sets a timeout status flag, which stays set. The time base is either the system clock divided by four or a slow tick from an external watchdog oscillator. That tick arrives as a clock-enable that is already synchronous to the system clock.

Software restarts the count through clear strobes, which come from the instruction decoder. The configuration word selects one of two clear disciplines. In single mode one strobe restarts the count. In paired mode both halves of a two-strobe pair must arrive, in either order. This makes it harder for a stray instruction to keep a faulty program alive. A halt strobe, raised when the core enters power-down, wipes the low (prescaler) part of the count. The upper divider part is kept.

Top module: `wdg_top`

## Requirements
- R1: Under synchronous reset and in the first cycle after it, `rst_req_o` and `timeout_o` are 0.
- R2: Configuration bit 1 selects the time base. With 0, the count advances once every 4 system clocks. With 1, it advances once per cycle in which `osc_tick_i` is high. The unselected source has no effect on the period.
- R3: With configuration bits [2+SEL_W:3] = s, the reset request comes 2^n counts after the count restarts, where n = PRE_W+DIV_W-2^SEL_W+1+s. With the default parameters n runs from 8 to 11.
- R4: `rst_req_o` is high for exactly one cycle. On that edge the count restarts from zero, so the next request follows after one more full period.
- R5: `timeout_o` is 0 until the first reset request. It rises together with that request and stays 1 until reset.
- R6: While configuration bit 0 is 0, no request is issued, every strobe has no effect, and the count is held at zero. After enabling, the first request comes after a full period.
- R7: With configuration bit 2 = 0 (single mode), a `clr_i` strobe restarts the count and the divide-by-4 phase. `clr1_i` and `clr2_i` are ignored.
- R8: With configuration bit 2 = 1 (paired mode), the count restarts only in the cycle where both halves have been seen. The halves may arrive in either order or in the same cycle. A repeated strobe of one half does not complete the pair, and `clr_i` is ignored.
- R9: A half that is pending is discarded whenever the count restarts, whether by pair completion or by timeout.
- R10: A `halt_i` strobe clears the low PRE_W bits of the count and the divide-by-4 phase, and keeps the upper DIV_W bits. It also suppresses a request in that cycle.
- R11: A qualifying clear in the same cycle as the final count wins: no request is issued and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | 3+SEL_W | Configuration: [0] enable, [1] time base, [2] clear mode, [2+SEL_W:3] timeout select |
| osc_tick_i | input | 1 | Watchdog oscillator tick, a one-cycle enable in the system clock domain |
| clr_i | input | 1 | Single clear strobe |
| clr1_i | input | 1 | First half of a paired clear |
| clr2_i | input | 1 | Second half of a paired clear |
| halt_i | input | 1 | Power-down entry strobe |
| rst_req_o | output | 1 | One-cycle reset request |
| timeout_o | output | 1 | Sticky timeout flag |

## Verification
The bench builds the block with PRE_W=4, DIV_W=3 and SEL_W=2, so the timeout exponent spans 4 to 7. At these sizes every combination of time base and timeout select can be swept to two full periods each, and the expected period is computed as 4·2^n clocks or 2^n ticks. The short periods also make the edge cases practical to cover: every ordering of the paired halves, a halt that keeps the upper divider bits, a clear that collides with the final count, and re-enabling after the block was disabled.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // configuration word layout
  localparam int CFG_EN   = 0;
  localparam int CFG_SRC  = 1;
  localparam int CFG_MODE = 2;
  localparam int CFG_TSEL = 3;

  typedef enum logic {SRC_SYSDIV = 1'b0, SRC_OSC = 1'b1} wdg_src_e;
  typedef enum logic {CLR_SINGLE = 1'b0, CLR_PAIRED = 1'b1} wdg_clr_e;
endpackage

// File: rtl/wdg_tick_src.sv
module wdg_tick_src #(
  parameter int SYS_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic osc_sel_i,
  input  logic osc_tick_i,
  input  logic restart_i,
  output logic tick_o
);
  logic sys_tick;

  generate
    if (SYS_DIV <= 1) begin : g_nodiv
      logic unused_nodiv;
      assign unused_nodiv = clk ^ rst ^ restart_i;
      assign sys_tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(SYS_DIV);
      logic [PW-1:0] phase_q;
      always_ff @(posedge clk) begin
        if (rst || restart_i)                 phase_q <= '0;
        else if (phase_q == PW'(SYS_DIV - 1)) phase_q <= '0;
        else                                  phase_q <= phase_q + 1'b1;
      end
      assign sys_tick = (phase_q == PW'(SYS_DIV - 1));
    end
  endgenerate

  assign tick_o = en_i & (osc_sel_i ? osc_tick_i : sys_tick);
endmodule

// File: rtl/wdg_clear_qual.sv
module wdg_clear_qual (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic paired_i,
  input  logic clr_i,
  input  logic clr1_i,
  input  logic clr2_i,
  input  logic ovf_i,
  output logic fire_o
);
  logic half1_q, half2_q;
  logic seen1, seen2;

  assign seen1  = half1_q | clr1_i;
  assign seen2  = half2_q | clr2_i;
  assign fire_o = en_i & (paired_i ? (seen1 & seen2) : clr_i);

  // pending halves are dropped on any count restart
  always_ff @(posedge clk) begin
    if (rst || !en_i || !paired_i || fire_o || ovf_i) begin
      half1_q <= 1'b0;
      half2_q <= 1'b0;
    end else begin
      half1_q <= seen1;
      half2_q <= seen2;
    end
  end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int PRE_W = 8,
  parameter int DIV_W = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic             halt_i,
  input  logic [SEL_W-1:0] tsel_i,
  output logic             ovf_o
);
  localparam int CNT_W = PRE_W + DIV_W;
  localparam int N_MIN = CNT_W - (1 << SEL_W) + 1;
  localparam logic [CNT_W-1:0] HI_MASK = ~CNT_W'((1 << PRE_W) - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  always_comb begin
    last_cnt = '0;
    for (int b = 0; b < CNT_W; b++) begin
      if (b < N_MIN + int'(tsel_i)) last_cnt[b] = 1'b1;
    end
  end

  assign ovf_o = en_i & tick_i & ~clear_i & ~halt_i & (cnt_q >= last_cnt);

  always_ff @(posedge clk) begin
    if (rst || !en_i || clear_i || ovf_o) cnt_q <= '0;
    else if (halt_i)                      cnt_q <= cnt_q & HI_MASK;
    else if (tick_i)                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter  int PRE_W   = 8,
  parameter  int DIV_W   = 3,
  parameter  int SEL_W   = 2,
  parameter  int SYS_DIV = 4,
  localparam int CFG_W   = CFG_TSEL + SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             osc_tick_i,
  input  logic             clr_i,
  input  logic             clr1_i,
  input  logic             clr2_i,
  input  logic             halt_i,
  output logic             rst_req_o,
  output logic             timeout_o
);
  logic             en, osc_sel, paired;
  logic [SEL_W-1:0] tsel;
  logic             halt_q, fire, tick, ovf;

  assign en      = cfg_i[CFG_EN];
  assign osc_sel = (wdg_src_e'(cfg_i[CFG_SRC]) == SRC_OSC);
  assign paired  = (wdg_clr_e'(cfg_i[CFG_MODE]) == CLR_PAIRED);
  assign tsel    = cfg_i[CFG_TSEL +: SEL_W];
  assign halt_q  = halt_i & en;

  wdg_tick_src #(.SYS_DIV(SYS_DIV)) u_src (
    .clk(clk), .rst(rst), .en_i(en), .osc_sel_i(osc_sel),
    .osc_tick_i(osc_tick_i), .restart_i(~en | fire | halt_q), .tick_o(tick)
  );

  wdg_clear_qual u_qual (
    .clk(clk), .rst(rst), .en_i(en), .paired_i(paired), .clr_i(clr_i),
    .clr1_i(clr1_i), .clr2_i(clr2_i), .ovf_i(ovf), .fire_o(fire)
  );

  wdg_counter #(.PRE_W(PRE_W), .DIV_W(DIV_W), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst(rst), .en_i(en), .tick_i(tick), .clear_i(fire),
    .halt_i(halt_q), .tsel_i(tsel), .ovf_o(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req_o <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      rst_req_o <= ovf;
      if (ovf) timeout_o <= 1'b1;
    end
  end
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk (
  input logic clk,
  input logic rst,
  input logic en_i,
  input logic paired_i,
  input logic clr_i,
  input logic halt_i,
  input logic rst_req_i,
  input logic timeout_i
);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rst_req_i |=> !rst_req_i);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    timeout_i |=> timeout_i);

  a_r5_flag_with_req: assert property (@(posedge clk) disable iff (rst)
    rst_req_i |-> timeout_i);

  a_r5_flag_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_i) |-> rst_req_i);

  a_r6_no_req_disabled: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !rst_req_i);

  a_r7_clear_blocks_req: assert property (@(posedge clk) disable iff (rst)
    (en_i && !paired_i && clr_i) |=> !rst_req_i);

  a_r10_halt_blocks_req: assert property (@(posedge clk) disable iff (rst)
    (en_i && halt_i) |=> !rst_req_i);
endmodule

bind wdg_top wdg_chk u_chk (
  .clk(clk), .rst(rst),
  .en_i(cfg_i[wdg_pkg::CFG_EN]), .paired_i(cfg_i[wdg_pkg::CFG_MODE]),
  .clr_i(clr_i), .halt_i(halt_i),
  .rst_req_i(rst_req_o), .timeout_i(timeout_o)
);

// File: tb/tb_wdg_top.sv
`timescale 1ns/1ps
module tb_wdg_top;
  localparam int PRE_W = 4, DIV_W = 3, SEL_W = 2, SYS_DIV = 4;
  localparam int N_MIN = PRE_W + DIV_W - (1 << SEL_W) + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [4:0] cfg = '0;
  logic osc_tick = 0, clr = 0, clr1 = 0, clr2 = 0, halt = 0;
  logic rst_req, timeout;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  wdg_top #(.PRE_W(PRE_W), .DIV_W(DIV_W), .SEL_W(SEL_W), .SYS_DIV(SYS_DIV)) dut (
    .clk(clk), .rst(rst), .cfg_i(cfg), .osc_tick_i(osc_tick), .clr_i(clr),
    .clr1_i(clr1), .clr2_i(clr2), .halt_i(halt), .rst_req_o(rst_req), .timeout_o(timeout)
  );

  always #2.5 clk = ~clk;

  task automatic chk_eq(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] mk(bit en, bit osc, bit pair, int ts);
    return {2'(ts), pair, osc, en};
  endfunction

  // 0 clr, 1 clr1, 2 clr2, 3 halt, 4 clr1+clr2; one edge
  task automatic pulse(input int which);
    clr  = (which == 0);
    clr1 = (which == 1) || (which == 4);
    clr2 = (which == 2) || (which == 4);
    halt = (which == 3);
    @(negedge clk);
    {clr, clr1, clr2, halt} = '0;
  endtask

  task automatic idle(input int k);
    osc_tick = 0;
    repeat (k) @(negedge clk);
  endtask

  task automatic run_to(input bit osc, input int e0, input int t0,
                        output int edges, output int ticks);
    edges = e0; ticks = t0;
    while (rst_req !== 1'b1 && edges < 4000) begin
      osc_tick = osc ? (edges % 3 != 1) : (edges % 2 == 0);
      @(negedge clk);
      if (osc && osc_tick) ticks++;
      edges++;
    end
    osc_tick = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    int e, t, cnt;
    repeat (3) @(negedge clk);
    chk_eq("R1 req in reset", rst_req, 0);
    chk_eq("R1 flag in reset", timeout, 0);
    rst = 0;
    @(negedge clk);
    chk_eq("R1 req after reset", rst_req, 0);
    chk_eq("R5 flag before first timeout", timeout, 0);

    // R2 R3 R4: sweep time base and timeout select
    for (int src = 0; src < 2; src++) begin
      for (int ts = 0; ts < 4; ts++) begin
        int n;
        n = N_MIN + ts;
        cfg = mk(1, src[0], 0, ts);
        pulse(0);
        run_to(src[0], 0, 0, e, t);
        if (src == 0) chk_eq("R2 R3 sysclk/4 period", e, 4 << n);
        else          chk_eq("R2 R3 osc period", t, 1 << n);
        chk_eq("R5 flag with request", timeout, 1);
        osc_tick = 1;
        @(negedge clk);
        osc_tick = 0;
        chk_eq("R4 one-cycle request", rst_req, 0);
        run_to(src[0], 1, src, e, t);
        if (src == 0) chk_eq("R4 restart sysclk/4", e, 4 << n);
        else          chk_eq("R4 restart osc", t, 1 << n);
      end
    end

    // R7 single mode clear and ignored halves (n=4 -> 64 clocks)
    cfg = mk(1, 0, 0, 0);
    pulse(0); idle(40);
    chk_eq("R7 no request before limit", rst_req, 0);
    pulse(0);
    run_to(0, 0, 0, e, t);
    chk_eq("R7 clear restarts count", e, 64);
    pulse(0); idle(20); pulse(1); idle(10); pulse(2);
    run_to(0, 32, 0, e, t);
    chk_eq("R7 paired halves ignored", e, 64);

    // R8 R9 paired mode
    cfg = mk(1, 0, 1, 0);
    pulse(1); idle(10); pulse(2);
    run_to(0, 0, 0, e, t);
    chk_eq("R8 clr1 then clr2", e, 64);
    idle(1); pulse(0); idle(8); pulse(1); idle(9); pulse(1);
    run_to(0, 21, 0, e, t);
    chk_eq("R8 single clear and repeated half ignored", e, 64);
    idle(1); pulse(2);
    run_to(0, 2, 0, e, t);
    chk_eq("R9 pending half dropped at timeout", e, 64);
    idle(1); pulse(2); idle(5); pulse(1);
    run_to(0, 0, 0, e, t);
    chk_eq("R8 reverse order", e, 64);
    idle(3); pulse(4);
    run_to(0, 0, 0, e, t);
    chk_eq("R8 both halves same cycle", e, 64);
    idle(2); pulse(1); pulse(2); idle(10); pulse(2);
    run_to(0, 11, 0, e, t);
    chk_eq("R9 pending dropped at pair completion", e, 64);

    // R10 halt keeps divider bits: osc, n=5, halt at count 20 -> 16
    cfg = mk(1, 1, 0, 1);
    idle(1); pulse(0);
    osc_tick = 1; repeat (20) @(negedge clk); osc_tick = 0;
    pulse(3);
    run_to(1, 0, 0, e, t);
    chk_eq("R10 halt clears prescaler only", t, 16);

    // R11 clear collides with final count: osc, n=4
    cfg = mk(1, 1, 0, 0);
    idle(1); pulse(0);
    osc_tick = 1; repeat (15) @(negedge clk);
    clr = 1;
    @(negedge clk);
    clr = 0; osc_tick = 0;
    chk_eq("R11 clear wins over timeout", rst_req, 0);
    run_to(1, 0, 0, e, t);
    chk_eq("R11 full period after collision", t, 16);

    // R6 disabled
    idle(1);
    osc_tick = 1; repeat (10) @(negedge clk); osc_tick = 0;
    cfg = mk(0, 1, 0, 0);
    cnt = 0;
    for (int i = 0; i < 400; i++) begin
      clr = (i % 7 == 0); clr1 = (i % 11 == 0); clr2 = (i % 13 == 0);
      halt = (i % 17 == 0); osc_tick = i[0];
      @(negedge clk);
      if (rst_req) cnt++;
    end
    {clr, clr1, clr2, halt, osc_tick} = '0;
    chk_eq("R6 no request while disabled", cnt, 0);
    chk_eq("R5 flag stays set", timeout, 1);
    cfg = mk(1, 1, 0, 0);
    run_to(1, 0, 0, e, t);
    chk_eq("R6 full period after enable", t, 16);

    // R1 reset clears flag
    rst = 1;
    idle(2);
    rst = 0;
    @(negedge clk);
    chk_eq("R1 reset clears flag", timeout, 0);
    chk_eq("R1 reset clears request", rst_req, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule